// File: doc/BRIEF.md
# Dual-Page Interprocessor Mailbox

This block lets two bus masters exchange short messages: a host side and a local-processor side. Each side has a simple synchronous register port. A read strobe returns data in the cycle after it is sampled. The mailbox holds two pages of eight 16-bit registers, one page for each direction.

On each page, word 0 is the status/command word and words 1 to 7 carry the payload. A sender fills the payload words first and then writes word 0, which notifies the other side.

- **Host to local.** Each host write to word 0 of the host-to-local page places a 16-bit vector in an eight-entry FIFO. The local side drains the FIFO one vector per pop. A level interrupt stays high while any vector is waiting.
- **Local to host.** A local write to word 0 of the local-to-host page sets a level interrupt toward the host. The host clears it by reading that word.

Top module: `xproc_mailbox`

## Requirements
- R1: Page select value 0 names the host-to-local page, which only the host port may write. Value 1 names the local-to-host page, which only the local port may write. A write from the other port leaves the page unchanged.
- R2: Either port may read either page. A read strobe in cycle n presents the word on that port's read data in cycle n+1, and the data holds until the next read. A read and a write of the same word in the same cycle return the old contents.
- R3: A host write to word 0 of the host-to-local page queues its low 14 data bits as a vector payload. Host writes to words 1 to 7 queue nothing.
- R4: A local write to word 0 of the local-to-host page sets the host interrupt. A host read of that word clears it. When both happen in the same cycle, the interrupt stays set.
- R5: The local interrupt is high, one cycle after each edge, exactly when the FIFO holds at least one vector.
- R6: A pop returns vectors in arrival order, with the layout bit 15 = last (no entry remains after this one), bit 14 = overflow flag, bits 13:0 = payload.
- R7: A pop on an empty FIFO returns 0xFFFF.
- R8: The FIFO holds 8 vectors. A vector that arrives while the FIFO is full, with no pop in the same cycle, is dropped and sets the overflow flag. The flag is reported in each popped vector and is cleared by the pop that empties the FIFO.
- R9: After reset both read data outputs are 0, both interrupts are low and the vector output is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_page | input | 1 | Host page select (0 host-to-local, 1 local-to-host) |
| h_addr | input | 3 | Host word index |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_irq | output | 1 | Interrupt toward host |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_page | input | 1 | Local page select (0 host-to-local, 1 local-to-host) |
| l_addr | input | 3 | Local word index |
| l_wdata | input | 16 | Local write data |
| l_rdata | output | 16 | Local read data |
| l_pop | input | 1 | Pop one vector from the FIFO |
| l_vec | output | 16 | Last popped vector |
| l_irq | output | 1 | Interrupt toward local side, FIFO non-empty |

## Verification
The assertions check the following on every cycle:
- the local interrupt rises only after a word-0 host write and falls only after a pop;
- the host interrupt rises only after a word-0 local write;
- an empty pop yields 0xFFFF;
- the last bit of a popped vector agrees with the interrupt that follows;
- read data holds between reads.

The remaining behaviour can only be shown by the bench's scenarios against its reference model: ownership filtering, read-before-write on a collision, FIFO ordering, dropping on a full FIFO and the overflow flag's lifetime.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef enum logic {
    PG_H2L = 1'b0,
    PG_L2H = 1'b1
  } mbx_page_e;

  localparam int unsigned VEC_LAST_BIT = 15;
  localparam int unsigned VEC_OVF_BIT  = 14;
endpackage

// File: rtl/mbx_page.sv
`timescale 1ns/1ps
module mbx_page #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ra_en,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic              rb_en,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data <= '0;
      rb_data <= '0;
    end else begin
      if (ra_en) ra_data <= mem[ra_addr];
      if (rb_en) rb_data <= mem[rb_addr];
    end
  end
endmodule

// File: rtl/mbx_vec_fifo.sv
`timescale 1ns/1ps
module mbx_vec_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PAY_W = 14,
  localparam int unsigned OUT_W = PAY_W + 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [PAY_W-1:0] pay,
  input  logic             pop,
  output logic [OUT_W-1:0] vec_q,
  output logic             irq_q
);
  logic [PAY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, cnt_next;
  logic             ovf;
  logic             do_pop, do_push, drop, last;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop   = pop && (count != '0);
    do_push  = push && ((count != CNT_W'(DEPTH)) || do_pop);
    drop     = push && !do_push;
    last     = do_pop && (count == CNT_W'(1)) && !do_push;
    cnt_next = count + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= pay;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      vec_q  <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= cnt_next;
      irq_q <= (cnt_next != '0);
      if (pop) begin
        if (count == '0) vec_q <= '1;
        else             vec_q <= {last, ovf, mem[rd_ptr]};
      end
      if (drop)      ovf <= 1'b1;
      else if (last) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/xproc_mailbox.sv
`timescale 1ns/1ps
module xproc_mailbox #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NREGS      = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned AW        = $clog2(NREGS),
  localparam int unsigned PAY_W     = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic              h_page,
  input  logic [AW-1:0]     h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_irq,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic              l_page,
  input  logic [AW-1:0]     l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_pop,
  output logic [DATA_W-1:0] l_vec,
  output logic              l_irq
);
  import mbx_pkg::*;

  logic [DATA_W-1:0] pg_ha [2];
  logic [DATA_W-1:0] pg_la [2];
  logic              h_sel_q, l_sel_q;
  logic              h_post, l_post, h_ack;

  for (genvar pg = 0; pg < 2; pg++) begin : g_page
    logic              we;
    logic [AW-1:0]     waddr;
    logic [DATA_W-1:0] wdata;
    if (pg == int'(PG_H2L)) begin : g_host_owned
      assign we    = h_wr && (h_page == PG_H2L);
      assign waddr = h_addr;
      assign wdata = h_wdata;
    end else begin : g_local_owned
      assign we    = l_wr && (l_page == PG_L2H);
      assign waddr = l_addr;
      assign wdata = l_wdata;
    end
    mbx_page #(.DATA_W(DATA_W), .NREGS(NREGS)) page_i (
      .clk    (clk),
      .rst    (rst),
      .we     (we),
      .waddr  (waddr),
      .wdata  (wdata),
      .ra_en  (h_rd && (h_page == 1'(pg))),
      .ra_addr(h_addr),
      .ra_data(pg_ha[pg]),
      .rb_en  (l_rd && (l_page == 1'(pg))),
      .rb_addr(l_addr),
      .rb_data(pg_la[pg])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_sel_q <= 1'b0;
      l_sel_q <= 1'b0;
    end else begin
      if (h_rd) h_sel_q <= h_page;
      if (l_rd) l_sel_q <= l_page;
    end
  end

  assign h_rdata = h_sel_q ? pg_ha[1] : pg_ha[0];
  assign l_rdata = l_sel_q ? pg_la[1] : pg_la[0];

  // doorbells: word 0 of the writer's own page
  assign h_post = h_wr && (h_page == PG_H2L) && (h_addr == '0);
  assign l_post = l_wr && (l_page == PG_L2H) && (l_addr == '0);
  assign h_ack  = h_rd && (h_page == PG_L2H) && (h_addr == '0);

  always_ff @(posedge clk) begin
    if (rst)         h_irq <= 1'b0;
    else if (l_post) h_irq <= 1'b1;
    else if (h_ack)  h_irq <= 1'b0;
  end

  mbx_vec_fifo #(.DEPTH(FIFO_DEPTH), .PAY_W(PAY_W)) fifo_i (
    .clk  (clk),
    .rst  (rst),
    .push (h_post),
    .pay  (h_wdata[PAY_W-1:0]),
    .pop  (l_pop),
    .vec_q(l_vec),
    .irq_q(l_irq)
  );
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              h_wr,
  input logic              h_rd,
  input logic              h_page,
  input logic [AW-1:0]     h_addr,
  input logic [DATA_W-1:0] h_rdata,
  input logic              h_irq,
  input logic              l_wr,
  input logic              l_rd,
  input logic              l_page,
  input logic [AW-1:0]     l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_pop,
  input logic [DATA_W-1:0] l_vec,
  input logic              l_irq
);
  p_hrdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !h_rd |=> $stable(h_rdata));
  p_lrdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !l_rd |=> $stable(l_rdata));
  p_hirq_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(h_irq) |-> $past(l_wr && l_page && (l_addr == '0)));
  p_lirq_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(l_irq) |-> $past(h_wr && !h_page && (h_addr == '0)));
  p_lirq_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(l_irq) |-> $past(l_pop));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (l_pop && !l_irq) |=> (l_vec == '1));
  p_last_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (l_pop && l_irq) |=> (l_vec[DATA_W-1] == !l_irq));
endmodule

bind xproc_mailbox mbx_checker #(.DATA_W(DATA_W), .AW(AW)) chk_i (
  .clk(clk), .rst(rst),
  .h_wr(h_wr), .h_rd(h_rd), .h_page(h_page), .h_addr(h_addr),
  .h_rdata(h_rdata), .h_irq(h_irq),
  .l_wr(l_wr), .l_rd(l_rd), .l_page(l_page), .l_addr(l_addr),
  .l_rdata(l_rdata), .l_pop(l_pop), .l_vec(l_vec), .l_irq(l_irq)
);

// File: tb/xproc_mailbox_tb_top.sv
`timescale 1ns/1ps
module xproc_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_wr = 0, h_rd = 0, h_page = 0;
  logic [2:0] h_addr = 0;
  logic [15:0] h_wdata = 0;
  logic l_wr = 0, l_rd = 0, l_page = 0, l_pop = 0;
  logic [2:0] l_addr = 0;
  logic [15:0] l_wdata = 0;
  logic [15:0] h_rdata, l_rdata, l_vec;
  logic h_irq, l_irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xproc_mailbox dut_i (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_page(h_page), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .l_wr(l_wr), .l_rd(l_rd), .l_page(l_page), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_pop(l_pop),
    .l_vec(l_vec), .l_irq(l_irq)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_h2l [8];
  logic [15:0] m_l2h [8];
  logic [13:0] m_q [$];
  logic        m_ovf, m_hirq, m_on = 0;
  logic [15:0] e_hr, e_lr, e_vec;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_ovf = 0; m_hirq = 0; e_hr = 0; e_lr = 0; e_vec = 16'hFFFF; m_on = 1;
    end else begin
      logic push, last, lpost, hack;
      push  = h_wr && !h_page && (h_addr == 0);
      lpost = l_wr && l_page && (l_addr == 0);
      hack  = h_rd && h_page && (h_addr == 0);
      if (h_rd) e_hr = h_page ? m_l2h[h_addr] : m_h2l[h_addr];
      if (l_rd) e_lr = l_page ? m_l2h[l_addr] : m_h2l[l_addr];
      if (l_pop) begin
        if (m_q.size() == 0) e_vec = 16'hFFFF;
        else begin
          last  = (m_q.size() == 1) && !push;
          e_vec = {last, m_ovf, m_q[0]};
          void'(m_q.pop_front());
          if (last) m_ovf = 0;
        end
      end
      if (push) begin
        if (m_q.size() < 8) m_q.push_back(h_wdata[13:0]);
        else m_ovf = 1;
      end
      if (lpost) m_hirq = 1;
      else if (hack) m_hirq = 0;
      if (h_wr && !h_page) m_h2l[h_addr] = h_wdata;
      if (l_wr && l_page)  m_l2h[l_addr] = l_wdata;
    end
  end

  task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_on && !finished) begin
      check16("R2 h_rdata model", h_rdata, e_hr);
      check16("R2 l_rdata model", l_rdata, e_lr);
      check16("R4 h_irq model", {15'b0, h_irq}, {15'b0, m_hirq});
      check16("R5 l_irq model", {15'b0, l_irq}, {15'b0, (m_q.size() != 0)});
      check16("R6 l_vec model", l_vec, e_vec);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hw(input logic pg, input logic [2:0] a, input logic [15:0] d);
    h_wr = 1; h_page = pg; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask
  task automatic lw(input logic pg, input logic [2:0] a, input logic [15:0] d);
    l_wr = 1; l_page = pg; l_addr = a; l_wdata = d;
    @(negedge clk); l_wr = 0;
  endtask
  task automatic hr(input logic pg, input logic [2:0] a, output logic [15:0] d);
    h_rd = 1; h_page = pg; h_addr = a;
    @(negedge clk); h_rd = 0; d = h_rdata;
  endtask
  task automatic lr(input logic pg, input logic [2:0] a, output logic [15:0] d);
    l_rd = 1; l_page = pg; l_addr = a;
    @(negedge clk); l_rd = 0; d = l_rdata;
  endtask
  task automatic pop(output logic [15:0] v);
    l_pop = 1;
    @(negedge clk); l_pop = 0; v = l_vec;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    check16("R9 h_rdata", h_rdata, 16'h0);
    check16("R9 l_rdata", l_rdata, 16'h0);
    check16("R9 irqs", {14'b0, h_irq, l_irq}, 16'h0);
    check16("R9 l_vec", l_vec, 16'hFFFF);

    for (int i = 0; i < 8; i++) hw(1'b0, 3'(i), 16'h1000 + 16'(i));
    for (int i = 0; i < 8; i++) lw(1'b1, 3'(i), 16'h2000 + 16'(i));
    check16("R4 set", {15'b0, h_irq}, 16'h1);
    hr(1'b1, 3'd1, d);
    check16("R4 other word keeps irq", {15'b0, h_irq}, 16'h1);
    hr(1'b1, 3'd0, d);
    check16("R4 clear", {15'b0, h_irq}, 16'h0);
    pop(d);
    check16("R6 init vector", d, 16'h9000);

    // R1 foreign writes ignored
    hw(1'b1, 3'd3, 16'hDEAD);
    lr(1'b1, 3'd3, d);
    check16("R1 host->L2H ignored", d, 16'h2003);
    lw(1'b0, 3'd5, 16'hBEEF);
    hr(1'b0, 3'd5, d);
    check16("R1 local->H2L ignored", d, 16'h1005);

    // R2 cross reads and collision
    lr(1'b0, 3'd2, d);
    check16("R2 local reads H2L", d, 16'h1002);
    hr(1'b1, 3'd7, d);
    check16("R2 host reads L2H", d, 16'h2007);
    h_wr = 1; h_page = 0; h_addr = 4; h_wdata = 16'h4444;
    l_rd = 1; l_page = 0; l_addr = 4;
    @(negedge clk); h_wr = 0; l_rd = 0;
    check16("R2 read-before-write", l_rdata, 16'h1004);
    lr(1'b0, 3'd4, d);
    check16("R2 new value", d, 16'h4444);

    // R3 only word 0 posts
    hw(1'b0, 3'd1, 16'h0777);
    check16("R3 data word no post", {15'b0, l_irq}, 16'h0);
    hw(1'b0, 3'd0, 16'h0123);
    check16("R5 irq up", {15'b0, l_irq}, 16'h1);
    pop(d);
    check16("R3 vector payload", d, 16'h8123);
    check16("R5 irq down", {15'b0, l_irq}, 16'h0);

    // R6 ordering
    hw(1'b0, 3'd0, 16'h0011);
    hw(1'b0, 3'd0, 16'h0022);
    hw(1'b0, 3'd0, 16'h0033);
    pop(d); check16("R6 first", d, 16'h0011);
    pop(d); check16("R6 second", d, 16'h0022);
    pop(d); check16("R6 last", d, 16'h8033);

    // R7 empty
    pop(d); check16("R7 empty pop", d, 16'hFFFF);

    // R8 overflow
    for (int k = 0; k < 10; k++) hw(1'b0, 3'd0, 16'h0100 + 16'(k));
    for (int k = 0; k < 7; k++) begin
      pop(d); check16("R8 flagged entry", d, 16'h4100 + 16'(k));
    end
    pop(d); check16("R8 final flagged", d, 16'hC107);
    pop(d); check16("R8 drained", d, 16'hFFFF);
    hw(1'b0, 3'd0, 16'h0055);
    pop(d); check16("R8 flag cleared", d, 16'h8055);

    // R4 set wins
    l_wr = 1; l_page = 1; l_addr = 0; l_wdata = 16'h2222;
    h_rd = 1; h_page = 1; h_addr = 0;
    @(negedge clk); l_wr = 0; h_rd = 0;
    check16("R4 set wins", {15'b0, h_irq}, 16'h1);
    hr(1'b1, 3'd0, d);

    // R6 simultaneous push and pop at one entry
    hw(1'b0, 3'd0, 16'h0007);
    h_wr = 1; h_page = 0; h_addr = 0; h_wdata = 16'h0008; l_pop = 1;
    @(negedge clk); h_wr = 0; l_pop = 0;
    check16("R6 push+pop not last", l_vec, 16'h0007);
    check16("R5 irq kept", {15'b0, l_irq}, 16'h1);
    pop(d); check16("R6 after push+pop", d, 16'h8008);

    // random traffic, checked against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      h_wr = ($urandom_range(0, 3) == 0); h_rd = $urandom_range(0, 1);
      h_page = 1'($urandom); h_addr = 3'($urandom_range(0, 7) < 3 ? 0 : $urandom);
      h_wdata = 16'($urandom);
      l_wr = ($urandom_range(0, 3) == 0); l_rd = $urandom_range(0, 1);
      l_page = 1'($urandom); l_addr = 3'($urandom);
      l_wdata = 16'($urandom); l_pop = ($urandom_range(0, 4) == 0);
      @(negedge clk);
    end
    {h_wr, h_rd, l_wr, l_rd, l_pop} = '0;
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule